// File: doc/BRIEF.md
# SMBus Host Controller Register File

This block is the register face of a small SMBus host controller as a 32-bit I/O bus sees it. Software writes individual byte lanes of a short run of 32-bit words. Five of those bytes have a function: status, control, target address, data and command. Every other byte in the window is plain storage that reads back what was last written into it.

A write to the control byte whose bits 2:1 hold binary 01 starts one single-byte transfer. The transfer uses the address, command, direction and data bytes as they stand at that moment. The block drives a simple request/response port toward the attached targets. It holds the request until the target acknowledges. On a read, it then stores the returned byte in the data register. Every finished transfer sets a done flag in the status byte, which software clears by writing a one to it.

The block is built with a parameter mask that lists which 7-bit addresses have a target behind them. A transfer to an address outside that mask never raises a request, but it still reports completion.

Top module: `smbus_host_regs`

## Requirements
- R1: Reset clears every byte of the window to zero, drives `busy` and `slv_req` low, and makes every word read back as 0.
- R2: The status byte sits in word 0, lane 0 (bits 7:0). Writing it clears each status bit written as one and leaves the others unchanged. Reading it returns the current status.
- R3: The control byte sits in word 0, lane 2 (bits 23:16) and reads back as written. A write to it starts a transfer only when the written bits 2:1 equal binary 01. Bits 0, 3 and up do not affect this decision (for example, 0x03 and 0x0A start a transfer, while 0x04 and 0x06 do not).
- R4: The address byte sits in word 1, lane 0. Its bits 7:1 are the 7-bit target address, and its bit 0 is the direction, where 0 means write and 1 means read.
- R5: A write transfer presents the target address, the command byte (word 2, lane 0), the data byte (word 1, lane 2) and `slv_rnw`=0 on the target port, and leaves the data byte unchanged.
- R6: A read transfer replaces the data byte with `slv_rdata` as sampled in the cycle where `slv_ack` is high.
- R7: Every finished transfer sets status bit 4 (value 0x10). This holds whether or not a target is attached.
- R8: A transfer to an address whose bit in the `ATTACHED` mask is 0 never raises `slv_req` and leaves the data byte unchanged. The default mask attaches addresses 0x10 and 0x45 only.
- R9: From the cycle after the start write until the acknowledge cycle, `busy` and `slv_req` stay high, and the address, direction, command and data presented to the target stay constant.
- R10: A start request written while `busy` is high is ignored, so it produces no extra request.
- R11: All other bytes of the window (word 0 lanes 1 and 3, word 1 lanes 1 and 3, word 2 lanes 1 to 3, word 3 all lanes) store and return their last written value.
- R12: A bus write changes only the byte lanes whose `bus_be` bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Bus write strobe, one cycle per write |
| bus_word | input | 2 | Word index within the window |
| bus_be | input | 4 | Byte-lane enables for the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the word selected by `bus_word` |
| busy | output | 1 | Transfer in progress |
| slv_req | output | 1 | Request to the target |
| slv_addr | output | 7 | Target address |
| slv_rnw | output | 1 | Direction, 1 = read |
| slv_cmd | output | 8 | Command byte |
| slv_wdata | output | 8 | Data byte for write transfers |
| slv_ack | input | 1 | Target acknowledge, ends the request |
| slv_rdata | input | 8 | Data returned by the target on a read |

## Verification
The bench decodes the start condition with control values that differ only in the bits outside 2:1. A design that tests the whole byte, or bit 1 alone, would then start on the wrong values or fail to start on the right ones. It clears the done flag with a write that has bit 4 at zero and then with one that has bit 4 at one, so a design that stores the status byte as plain data, or clears all bits at once, would show the wrong status. It sends a transfer to an address with no target and checks that no request appears and that the done flag still rises. It also writes a second start while a slow target holds the request, and counts requests to catch a design that re-arms while busy or lets the operands move mid-handshake.

// File: rtl/smbh_pkg.sv
package smbh_pkg;

    localparam int LANES       = 4;
    localparam int SLV_ADDR_W  = 7;
    localparam int SLV_COUNT   = 1 << SLV_ADDR_W;

    // byte placement of the functional registers (software-visible map)
    localparam int STATUS_WORD = 0;
    localparam int STATUS_LANE = 0;
    localparam int CTRL_WORD   = 0;
    localparam int CTRL_LANE   = 2;
    localparam int ADDR_WORD   = 1;
    localparam int ADDR_LANE   = 0;
    localparam int DATA_WORD   = 1;
    localparam int DATA_LANE   = 2;
    localparam int CMD_WORD    = 2;
    localparam int CMD_LANE    = 0;

    localparam int DONE_BIT    = 4;

    typedef enum logic [2:0] {
        LK_PLAIN,
        LK_STATUS,
        LK_CTRL,
        LK_ADDR,
        LK_DATA,
        LK_CMD
    } lane_kind_e;

    typedef enum logic {
        XS_IDLE,
        XS_REQ
    } xfer_state_e;

    typedef struct packed {
        logic [SLV_ADDR_W-1:0] addr;
        logic                  rnw;
        logic [7:0]            cmd;
        logic [7:0]            data;
    } xfer_t;

    function automatic lane_kind_e lane_kind(int w, int l);
        if (w == STATUS_WORD && l == STATUS_LANE) return LK_STATUS;
        if (w == CTRL_WORD   && l == CTRL_LANE)   return LK_CTRL;
        if (w == ADDR_WORD   && l == ADDR_LANE)   return LK_ADDR;
        if (w == DATA_WORD   && l == DATA_LANE)   return LK_DATA;
        if (w == CMD_WORD    && l == CMD_LANE)    return LK_CMD;
        return LK_PLAIN;
    endfunction

    // transfer is launched only for control bits 2:1 == 01
    function automatic logic is_start_code(logic [7:0] ctrl);
        return ctrl[2:1] == 2'b01;
    endfunction

endpackage

// File: rtl/smbh_regfile.sv
module smbh_regfile
    import smbh_pkg::*;
#(
    parameter int NUM_WORDS = 4,
    localparam int WIDX_W   = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [WIDX_W-1:0] word,
    input  logic [LANES-1:0]  be,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              busy,
    input  logic              done,
    input  logic              rd_valid,
    input  logic [7:0]        rd_data,
    output logic              start,
    output xfer_t             xfer
);

    logic [NUM_WORDS-1:0][LANES*8-1:0] words_w;

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            localparam lane_kind_e KIND = lane_kind(w, l);
            logic [7:0] byte_q;
            logic [7:0] byte_d;
            logic       hit;
            logic [7:0] wbyte;

            assign hit   = wr && (word == WIDX_W'(w)) && be[l];
            assign wbyte = wdata[l*8 +: 8];

            if (KIND == LK_STATUS) begin : g_status
                always_comb begin
                    byte_d = hit ? (byte_q & ~wbyte) : byte_q;
                    if (done) byte_d[DONE_BIT] = 1'b1;
                end
            end else if (KIND == LK_DATA) begin : g_data
                always_comb begin
                    if (rd_valid)  byte_d = rd_data;
                    else if (hit)  byte_d = wbyte;
                    else           byte_d = byte_q;
                end
            end else begin : g_plain
                assign byte_d = hit ? wbyte : byte_q;
            end

            always_ff @(posedge clk) begin
                if (rst) byte_q <= '0;
                else     byte_q <= byte_d;
            end

            assign words_w[w][l*8 +: 8] = byte_q;
        end
    end

    logic [7:0] status_b;
    logic [7:0] data_b;
    logic       ctrl_hit;

    assign status_b = words_w[STATUS_WORD][STATUS_LANE*8 +: 8];
    assign data_b   = words_w[DATA_WORD][DATA_LANE*8 +: 8];

    assign rdata = words_w[word];

    assign xfer.addr = words_w[ADDR_WORD][ADDR_LANE*8+1 +: SLV_ADDR_W];
    assign xfer.rnw  = words_w[ADDR_WORD][ADDR_LANE*8];
    assign xfer.cmd  = words_w[CMD_WORD][CMD_LANE*8 +: 8];
    assign xfer.data = data_b;

    assign ctrl_hit = wr && (word == WIDX_W'(CTRL_WORD)) && be[CTRL_LANE];
    assign start    = ctrl_hit && is_start_code(wdata[CTRL_LANE*8 +: 8]) && !busy;

    AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        done |=> status_b[DONE_BIT]); // R7

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (wr && word == WIDX_W'(STATUS_WORD) && be[STATUS_LANE]
            && wdata[STATUS_LANE*8 + DONE_BIT] && !done)
        |=> !status_b[DONE_BIT]); // R2

    AST_READ_LOADS_DATA: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> data_b == $past(rd_data)); // R6

    AST_NO_START_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |-> !start); // R10

endmodule

// File: rtl/smbh_xfer.sv
module smbh_xfer
    import smbh_pkg::*;
#(
    parameter logic [SLV_COUNT-1:0] ATTACHED = '0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  xfer_t                 xfer_in,
    output logic                  busy,
    output logic                  done,
    output logic                  rd_valid,
    output logic [7:0]            rd_data,
    output logic                  slv_req,
    output logic [SLV_ADDR_W-1:0] slv_addr,
    output logic                  slv_rnw,
    output logic [7:0]            slv_cmd,
    output logic [7:0]            slv_wdata,
    input  logic                  slv_ack,
    input  logic [7:0]            slv_rdata
);

    xfer_state_e state_q;
    xfer_t       cur_q;
    logic        present;

    assign present = ATTACHED[xfer_in.addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= XS_IDLE;
            cur_q   <= '0;
        end else begin
            case (state_q)
                XS_IDLE: begin
                    if (start) begin
                        cur_q <= xfer_in;
                        if (present) state_q <= XS_REQ;
                    end
                end
                XS_REQ: begin
                    if (slv_ack) state_q <= XS_IDLE;
                end
                default: state_q <= XS_IDLE;
            endcase
        end
    end

    assign busy      = (state_q == XS_REQ);
    assign slv_req   = busy;
    assign slv_addr  = cur_q.addr;
    assign slv_rnw   = cur_q.rnw;
    assign slv_cmd   = cur_q.cmd;
    assign slv_wdata = cur_q.data;

    assign done     = (state_q == XS_IDLE && start && !present)
                   || (busy && slv_ack);
    assign rd_valid = busy && slv_ack && cur_q.rnw;
    assign rd_data  = slv_rdata;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (slv_req && !slv_ack) |=> slv_req); // R9

    AST_OPERANDS_STABLE: assert property (@(posedge clk) disable iff (rst)
        (slv_req && !slv_ack) |=> ($stable(slv_addr) && $stable(slv_rnw)
                                   && $stable(slv_cmd) && $stable(slv_wdata))); // R9

    AST_ONLY_ATTACHED: assert property (@(posedge clk) disable iff (rst)
        slv_req |-> ATTACHED[slv_addr]); // R8

    AST_REQ_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
        $rose(slv_req) |-> $past(start)); // R10

endmodule

// File: rtl/smbus_host_regs.sv
module smbus_host_regs
    import smbh_pkg::*;
#(
    parameter int NUM_WORDS = 4,
    parameter logic [SLV_COUNT-1:0] ATTACHED = (SLV_COUNT'(1) << 'h45) | (SLV_COUNT'(1) << 'h10),
    localparam int WIDX_W = $clog2(NUM_WORDS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_wr,
    input  logic [WIDX_W-1:0]     bus_word,
    input  logic [LANES-1:0]      bus_be,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    output logic                  busy,
    output logic                  slv_req,
    output logic [SLV_ADDR_W-1:0] slv_addr,
    output logic                  slv_rnw,
    output logic [7:0]            slv_cmd,
    output logic [7:0]            slv_wdata,
    input  logic                  slv_ack,
    input  logic [7:0]            slv_rdata
);

    logic  start;
    logic  done;
    logic  rd_valid;
    logic  [7:0] rd_data;
    xfer_t xfer;

    smbh_regfile #(
        .NUM_WORDS (NUM_WORDS)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (bus_wr),
        .word     (bus_word),
        .be       (bus_be),
        .wdata    (bus_wdata),
        .rdata    (bus_rdata),
        .busy     (busy),
        .done     (done),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .start    (start),
        .xfer     (xfer)
    );

    smbh_xfer #(
        .ATTACHED (ATTACHED)
    ) u_xfer (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .xfer_in   (xfer),
        .busy      (busy),
        .done      (done),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .slv_req   (slv_req),
        .slv_addr  (slv_addr),
        .slv_rnw   (slv_rnw),
        .slv_cmd   (slv_cmd),
        .slv_wdata (slv_wdata),
        .slv_ack   (slv_ack),
        .slv_rdata (slv_rdata)
    );

endmodule

// File: tb/tb_smbus_host_regs.sv
module tb_smbus_host_regs;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_word = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        busy;
    logic        slv_req;
    logic [6:0]  slv_addr;
    logic        slv_rnw;
    logic [7:0]  slv_cmd;
    logic [7:0]  slv_wdata;
    logic        slv_ack = 1'b0;
    logic [7:0]  slv_rdata = '0;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // target model state
    int         ack_delay = 0;
    int         wait_cnt  = 0;
    int         req_count = 0;
    logic       prev_req  = 1'b0;
    logic [6:0] cap_addr;
    logic       cap_rnw;
    logic [7:0] cap_cmd;
    logic [7:0] cap_wdata;

    always #4 clk = ~clk;

    smbus_host_regs dut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_word  (bus_word),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (busy),
        .slv_req   (slv_req),
        .slv_addr  (slv_addr),
        .slv_rnw   (slv_rnw),
        .slv_cmd   (slv_cmd),
        .slv_wdata (slv_wdata),
        .slv_ack   (slv_ack),
        .slv_rdata (slv_rdata)
    );

    always @(negedge clk) begin
        if (rst) begin
            wait_cnt = 0;
            slv_ack  = 1'b0;
            prev_req = 1'b0;
        end else begin
            if (slv_req && !prev_req) begin
                req_count++;
                wait_cnt = 0;
            end
            prev_req = slv_req;
            if (slv_req) begin
                slv_ack = (wait_cnt >= ack_delay);
                if (slv_ack) begin
                    cap_addr  = slv_addr;
                    cap_rnw   = slv_rnw;
                    cap_cmd   = slv_cmd;
                    cap_wdata = slv_wdata;
                end
                wait_cnt++;
            end else begin
                slv_ack = 1'b0;
            end
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(logic [1:0] w, logic [3:0] be, logic [31:0] d);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_word  = w;
        bus_be    = be;
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        bus_be = '0;
    endtask

    task automatic bus_read(logic [1:0] w, output logic [31:0] d);
        @(negedge clk);
        bus_word = w;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (!busy) break;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic clear_status();
        bus_write(2'd0, 4'b0001, 32'h0000_00FF);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int w = 0; w < 4; w++) begin
            bus_read(w[1:0], d);
            check("R1 word after reset", d, 32'h0);
        end
        check("R1 busy after reset", {31'b0, busy}, 32'h0);
        check("R1 slv_req after reset", {31'b0, slv_req}, 32'h0);
    endtask

    task automatic t_plain_lanes();
        logic [31:0] d;
        bus_write(2'd3, 4'b1111, 32'hA1B2_C3D4);
        bus_read(2'd3, d);
        check("R11 word3 storage", d, 32'hA1B2_C3D4);
        bus_write(2'd0, 4'b1010, 32'h5A00_7E00);
        bus_read(2'd0, d);
        check("R11 word0 spare lanes", d, 32'h5A00_7E00);
        bus_write(2'd3, 4'b0001, 32'hFFFF_FF11);
        bus_read(2'd3, d);
        check("R12 lane mask", d, 32'hA1B2_C311);
        bus_write(2'd2, 4'b1110, 32'h1234_5699);
        bus_read(2'd2, d);
        check("R11 word2 spare lanes", d, 32'h1234_5600);
    endtask

    task automatic t_write_xfer();
        logic [31:0] d;
        int base;
        base = req_count;
        ack_delay = 2;
        bus_write(2'd1, 4'b0101, 32'h003C_008A);
        bus_write(2'd2, 4'b0001, 32'h0000_0077);
        bus_write(2'd0, 4'b0100, 32'h0002_0000);
        check("R9 busy during handshake", {31'b0, busy}, 32'h1);
        check("R9 slv_req during handshake", {31'b0, slv_req}, 32'h1);
        wait_idle();
        check("R5 one request", req_count - base, 1);
        check("R4 target address", {25'b0, cap_addr}, 32'h45);
        check("R5 direction write", {31'b0, cap_rnw}, 32'h0);
        check("R5 command byte", {24'b0, cap_cmd}, 32'h77);
        check("R5 data byte", {24'b0, cap_wdata}, 32'h3C);
        bus_read(2'd1, d);
        check("R5 data unchanged", d, 32'h003C_008A);
        bus_read(2'd0, d);
        check("R7 done flag and R3 control readback", d, 32'h5A02_7E10);
    endtask

    task automatic t_status_w1c();
        logic [31:0] d;
        bus_write(2'd0, 4'b0001, 32'h0000_00EF);
        bus_read(2'd0, d);
        check("R2 zero bits keep status", d & 32'hFF, 32'h10);
        bus_write(2'd0, 4'b0001, 32'h0000_0010);
        bus_read(2'd0, d);
        check("R2 one bit clears status", d & 32'hFF, 32'h00);
    endtask

    task automatic t_read_xfer();
        logic [31:0] d;
        int base;
        base = req_count;
        ack_delay = 0;
        slv_rdata = 8'hC7;
        bus_write(2'd1, 4'b0101, 32'h0000_008B);
        bus_write(2'd0, 4'b0100, 32'h0003_0000);
        wait_idle();
        check("R3 code 0x03 starts", req_count - base, 1);
        check("R4 direction read", {31'b0, cap_rnw}, 32'h1);
        bus_read(2'd1, d);
        check("R6 data replaced", d, 32'h00C7_008B);
        bus_read(2'd0, d);
        check("R7 done after read", d & 32'hFF, 32'h10);
        clear_status();
    endtask

    task automatic t_ctrl_decode();
        logic [31:0] d;
        int base;
        base = req_count;
        bus_write(2'd0, 4'b0100, 32'h0006_0000);
        bus_write(2'd0, 4'b0100, 32'h0004_0000);
        repeat (5) @(negedge clk);
        check("R3 codes 0x06/0x04 no start", req_count - base, 0);
        bus_read(2'd0, d);
        check("R3 no done without start", d & 32'hFF, 32'h00);
        check("R3 control readback", (d >> 16) & 32'hFF, 32'h04);
        bus_write(2'd0, 4'b0100, 32'h000A_0000);
        wait_idle();
        check("R3 code 0x0A starts", req_count - base, 1);
        clear_status();
    endtask

    task automatic t_unattached();
        logic [31:0] d;
        int base;
        base = req_count;
        bus_write(2'd1, 4'b0101, 32'h005E_0045);
        bus_write(2'd0, 4'b0100, 32'h0002_0000);
        repeat (6) @(negedge clk);
        check("R8 no request to absent target", req_count - base, 0);
        bus_read(2'd1, d);
        check("R8 data unchanged", d, 32'h005E_0045);
        bus_read(2'd0, d);
        check("R7 done without target", d & 32'hFF, 32'h10);
        clear_status();
    endtask

    task automatic t_busy_ignore();
        int base;
        base = req_count;
        ack_delay = 6;
        bus_write(2'd1, 4'b0101, 32'h0011_0020);
        bus_write(2'd0, 4'b0100, 32'h0002_0000);
        check("R9 busy after start", {31'b0, busy}, 32'h1);
        bus_write(2'd0, 4'b0100, 32'h0002_0000);
        check("R9 still busy", {31'b0, busy}, 32'h1);
        wait_idle();
        repeat (8) @(negedge clk);
        check("R10 start while busy ignored", req_count - base, 1);
        check("R9 address held", {25'b0, cap_addr}, 32'h10);
        clear_status();
    endtask

    task automatic t_reset_again();
        logic [31:0] d;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int w = 0; w < 4; w++) begin
            bus_read(w[1:0], d);
            check("R1 word after second reset", d, 32'h0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_plain_lanes();
        t_write_xfer();
        t_status_w1c();
        t_read_xfer();
        t_ctrl_decode();
        t_unattached();
        t_busy_ignore();
        t_reset_again();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule